// File: doc/BRIEF.md
# Frame Slip Elastic Buffer

This block is the receive elastic store for a framed stream of 32 timeslots per frame. Words arrive on the write side at the rate of the far end. They leave on the read side at the rate of the local timebase. Both sides are expressed as enable strobes in one common clock. The store holds two frames. When the write position comes too close behind the read position, or pulls too far ahead of it, the buffer moves the read position by exactly one whole frame. A move backwards outputs a frame a second time. A move forwards discards a frame.

Slips are evaluated only while the framer reports that frame alignment is held. On the first read frame start after alignment is regained, the read position is placed half a buffer away from the writer. No slip is counted for this placement. Each slip sets a sticky status flag and updates a direction flag. The sticky flag drives a maskable interrupt. The direction flag never interrupts.

Top module: `frame_slip_buffer`

## Requirements
- R1: A slip is taken only on a read strobe that carries the read frame-start marker. A slip moves the read address to the first word of the neighbouring frame, exactly 32 words forward or back, so the output never contains a partial frame.
- R2: While `frame_ok` is 0, no slip is taken and reads continue at consecutive addresses. On the first read frame start with `frame_ok` at 1 after it was 0 (or after reset), the read address becomes the base of the frame half a buffer away from the frame the write pointer is in. No slip is reported for this placement.
- R3: At a locked read frame start, let fill = (write pointer − read pointer) mod 64, where each pointer is the next address to be used. If fill < 8, the previous frame is repeated: `skip` goes to 1 and `slc` goes to 0.
- R4: At a locked read frame start with fill > 56, the next frame is discarded: `skip` goes to 1 and `slc` goes to 1.
- R5: With fill from 8 to 56, no slip is taken. `rd_data` is the word last written at the read address, presented the cycle after the read strobe.
- R6: `irq` equals `skip` AND NOT `skip_mask`. `slc` never affects `irq`.
- R7: `skip` stays 1 until a `stat_rd` pulse clears it. A slip in the same cycle wins over the clear. `slc` keeps its value across the clear.
- R8: After reset, `skip`, `slc` and `irq` are 0.
- R9: A write that carries `wr_fs` while the write pointer is partway through a frame goes to word 0 of the next frame. The writes that follow continue from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_fs | input | 1 | Marks the written word as timeslot 0 |
| wr_data | input | 8 | Word written into the store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_fs | input | 1 | Marks the read as the first word of an output frame |
| rd_data | output | 8 | Word read, valid the cycle after `rd_en` |
| frame_ok | input | 1 | Frame alignment held; enables slip handling |
| skip_mask | input | 1 | 1 suppresses the interrupt from `skip` |
| stat_rd | input | 1 | Status read pulse; clears `skip` |
| skip | output | 1 | Sticky: a whole frame was repeated or discarded |
| slc | output | 1 | Direction of the last slip: 1 discarded, 0 repeated |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep starts each run from a locked, half-buffer spacing. It writes between 0 and 63 extra words before the next read frame start, which covers every fill value. This separates the repeat band, the discard band and the quiet band, including the edges at 7/8 and 56/57, and every output word is compared with the word written last at its address. A steady pattern of simultaneous writes and reads over several frames shows that matched rates never slip. Separate patterns cover the frame-start realignment of the write side, lost alignment with later relock, clearing the status on read, and the interrupt mask.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

  // Words the writer is ahead of the reader, modulo the store depth.
  function automatic int fill_of(int wp, int rp, int depth);
    return (wp - rp + depth) % depth;
  endfunction

  // Decide on a frame slip from the fill at a read frame start.
  function automatic slip_e classify(int fill, int guard, int depth);
    if (fill < guard)         return SLIP_REPEAT;
    if (fill > depth - guard) return SLIP_DROP;
    return SLIP_NONE;
  endfunction

endpackage

// File: rtl/fsb_wr_ctrl.sv
module fsb_wr_ctrl #(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 2,
  localparam int DEPTH = SLOTS * FRAMES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fs,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] wptr
);

  // Round a pointer up to the next frame base (unchanged if already there).
  function automatic logic [AW-1:0] base_up(logic [AW-1:0] p);
    int f;
    if (int'(p) % SLOTS == 0) return p;
    f = (int'(p) / SLOTS + 1) % FRAMES;
    return AW'(f * SLOTS);
  endfunction

  always_comb wr_addr = wr_fs ? base_up(wptr) : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wptr <= '0;
    else if (wr_en) wptr <= wr_addr + AW'(1);
  end

endmodule

// File: rtl/fsb_store.sv
module fsb_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fsb_rd_ctrl.sv
module fsb_rd_ctrl #(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 2,
  parameter int GUARD  = 8,
  localparam int DEPTH = SLOTS * FRAMES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_fs,
  input  logic          frame_ok,
  input  logic [AW-1:0] wptr,
  output logic [AW-1:0] rd_addr,
  output logic          slip_ev,
  output logic          slip_drop
);
  import fsb_pkg::*;

  logic [AW-1:0] rptr;
  logic          locked;
  slip_e         kind;
  int            fill;

  // Frame base half a buffer away from the writer's current frame.
  function automatic logic [AW-1:0] lock_base(logic [AW-1:0] w);
    int f;
    f = (int'(w) / SLOTS + FRAMES - FRAMES / 2) % FRAMES;
    return AW'(f * SLOTS);
  endfunction

  // Base of the frame one whole frame forward (drop) or back (repeat).
  function automatic logic [AW-1:0] slip_base(logic [AW-1:0] r, logic drop);
    int b;
    b = (int'(r) / SLOTS) * SLOTS;
    return drop ? AW'((b + SLOTS) % DEPTH) : AW'((b + DEPTH - SLOTS) % DEPTH);
  endfunction

  always_comb begin
    fill      = fill_of(int'(wptr), int'(rptr), DEPTH);
    kind      = classify(fill, GUARD, DEPTH);
    rd_addr   = rptr;
    slip_ev   = 1'b0;
    slip_drop = 1'b0;
    if (rd_en && rd_fs && frame_ok) begin
      if (!locked) begin
        rd_addr = lock_base(wptr);
      end else if (kind != SLIP_NONE) begin
        slip_ev   = 1'b1;
        slip_drop = (kind == SLIP_DROP);
        rd_addr   = slip_base(rptr, slip_drop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      locked <= 1'b0;
    end else begin
      if (rd_en)                       rptr   <= rd_addr + AW'(1);
      if (!frame_ok)                   locked <= 1'b0;
      else if (rd_en && rd_fs)         locked <= 1'b1;
    end
  end

endmodule

// File: rtl/fsb_status.sv
module fsb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic slip_ev,
  input  logic slip_drop,
  input  logic stat_rd,
  input  logic skip_mask,
  output logic skip,
  output logic slc,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip <= 1'b0;
      slc  <= 1'b0;
    end else begin
      if (slip_ev)      skip <= 1'b1;
      else if (stat_rd) skip <= 1'b0;
      if (slip_ev)      slc  <= slip_drop;
    end
  end

  always_comb irq = skip & ~skip_mask;

endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer #(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 2,
  parameter int DW     = 8,
  parameter int GUARD  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fs,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_fs,
  output logic [DW-1:0] rd_data,
  input  logic          frame_ok,
  input  logic          skip_mask,
  input  logic          stat_rd,
  output logic          skip,
  output logic          slc,
  output logic          irq
);
  localparam int DEPTH = SLOTS * FRAMES;
  localparam int AW    = $clog2(DEPTH);

  logic [AW-1:0] wr_addr;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rd_addr;
  logic          slip_ev;
  logic          slip_drop;

  fsb_wr_ctrl #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fs(wr_fs),
    .wr_addr(wr_addr), .wptr(wptr)
  );

  fsb_store #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fsb_rd_ctrl #(.SLOTS(SLOTS), .FRAMES(FRAMES), .GUARD(GUARD)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_fs(rd_fs),
    .frame_ok(frame_ok), .wptr(wptr), .rd_addr(rd_addr),
    .slip_ev(slip_ev), .slip_drop(slip_drop)
  );

  fsb_status u_st (
    .clk(clk), .rst_n(rst_n), .slip_ev(slip_ev), .slip_drop(slip_drop),
    .stat_rd(stat_rd), .skip_mask(skip_mask),
    .skip(skip), .slc(slc), .irq(irq)
  );

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic rd_fs,
  input logic frame_ok,
  input logic skip_mask,
  input logic stat_rd,
  input logic slip_ev,
  input logic slip_drop,
  input logic skip,
  input logic slc,
  input logic irq
);

  a_r1_slip_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    slip_ev |-> (rd_en && rd_fs));

  a_r2_no_slip_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> !slip_ev);

  a_r3_slip_sets_skip: assert property (@(posedge clk) disable iff (!rst_n)
    slip_ev |=> skip);

  a_r3_repeat_clears_slc: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ev && !slip_drop) |=> !slc);

  a_r4_drop_sets_slc: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ev && slip_drop) |=> slc);

  a_r6_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    skip_mask |-> !irq);

  a_r6_irq_needs_skip: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> skip);

  a_r7_read_clears_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !slip_ev) |=> !skip);

  a_r7_slc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_ev |=> $stable(slc));

endmodule

bind frame_slip_buffer fsb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_fs(rd_fs),
  .frame_ok(frame_ok), .skip_mask(skip_mask), .stat_rd(stat_rd),
  .slip_ev(slip_ev), .slip_drop(slip_drop),
  .skip(skip), .slc(slc), .irq(irq)
);

// File: tb/sim_frame_slip_buffer.sv
module sim_frame_slip_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_fs = 0, rd_en = 0, rd_fs = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       frame_ok = 0, skip_mask = 0, stat_rd = 0;
  logic       skip, slc, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int pend_exp = -1;
  bit pend = 0;
  string pend_req = "R5";

  always #10 clk = ~clk;

  frame_slip_buffer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fs(wr_fs), .wr_data(wr_data),
    .rd_en(rd_en), .rd_fs(rd_fs), .rd_data(rd_data), .frame_ok(frame_ok),
    .skip_mask(skip_mask), .stat_rd(stat_rd), .skip(skip), .slc(slc), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One cycle: sample the previous read result, then drive new inputs.
  task automatic step(input bit we, input bit wfs, input int wd,
                      input bit re, input bit rfs, input int exp);
    @(negedge clk);
    if (pend && pend_exp >= 0)
      check(rd_data == 8'(pend_exp), pend_req, int'(rd_data), pend_exp);
    wr_en = we; wr_fs = wfs; wr_data = 8'(wd);
    rd_en = re; rd_fs = rfs;
    pend = re; pend_exp = exp;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, -1);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; wr_en = 0; wr_fs = 0; rd_en = 0; rd_fs = 0;
    stat_rd = 0; skip_mask = 0; frame_ok = 0; pend = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic status(input string req, input bit es, input bit ec, input bit ei);
    check(skip == es, req, int'(skip), int'(es));
    check(slc == ec, req, int'(slc), int'(ec));
    check(irq == ei, req, int'(irq), int'(ei));
  endtask

  // Last data value written at address a when words 0..total-1 went to n mod 64.
  function automatic int last_at(int a, int total);
    if (a + 64 < total) return a + 64;
    if (a < total) return a;
    return -1;
  endfunction

  // Locked start: 32 words written, one frame read; then k more words.
  task automatic prime(input int k);
    reset_dut();
    frame_ok = 1;
    for (int n = 0; n < 32; n++) step(1, n == 0, n, 0, 0, -1);
    pend_req = "R2";
    for (int j = 0; j < 32; j++) step(0, 0, 0, 1, j == 0, j);
    for (int n = 32; n < 32 + k; n++) step(1, 0, n, 0, 0, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    // R8: reset state
    reset_dut();
    idle();
    status("R8", 0, 0, 0);

    // R3/R4/R5 sweep over every fill value
    for (int k = 0; k < 64; k++) begin
      bit rep, drp;
      int base;
      rep  = (k < 8);
      drp  = (k > 56);
      base = (rep || drp) ? 0 : 32;
      prime(k);
      pend_req = rep ? "R3" : (drp ? "R4" : "R5");
      for (int j = 0; j < 32; j++) begin
        step(0, 0, 0, 1, j == 0, last_at(base + j, 32 + k));
        if (j == 1) begin
          if (rep)      status("R3", 1, 0, 1);
          else if (drp) status("R4", 1, 1, 1);
          else          status("R5", 0, 0, 0);
        end
      end
      idle();
    end

    // R1: matched rates over several frames never slip
    reset_dut();
    frame_ok = 1;
    for (int n = 0; n < 32; n++) step(1, n == 0, n, 0, 0, -1);
    pend_req = "R1";
    for (int f = 1; f < 6; f++)
      for (int j = 0; j < 32; j++)
        step(1, j == 0, f * 32 + j, 1, j == 0, (f - 1) * 32 + j);
    idle();
    status("R1", 0, 0, 0);

    // R7: clear on status read, slc held
    prime(60);
    step(0, 0, 0, 1, 1, -1);
    idle();
    status("R7", 1, 1, 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    status("R7", 0, 1, 0);

    // R7: slip and clear in the same cycle, slip wins
    prime(3);
    @(negedge clk);
    stat_rd = 1; rd_en = 1; rd_fs = 1; pend = 0;
    @(negedge clk);
    stat_rd = 0; rd_en = 0; rd_fs = 0;
    status("R7", 1, 0, 1);

    // R6: mask suppresses interrupt, unmask restores it
    prime(60);
    skip_mask = 1;
    step(0, 0, 0, 1, 1, -1);
    idle();
    status("R6", 1, 1, 0);
    skip_mask = 0;
    #1;
    check(irq == 1'b1, "R6", int'(irq), 1);

    // R2: no slip while alignment is lost, relock without report
    prime(2);
    frame_ok = 0;
    pend_req = "R2";
    step(0, 0, 0, 1, 1, 32);
    step(0, 0, 0, 1, 0, 33);
    idle();
    status("R2", 0, 0, 0);
    frame_ok = 1;
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 1);
    idle();
    status("R2", 0, 0, 0);

    // R9: write frame start mid-frame realigns to next frame base
    reset_dut();
    frame_ok = 1;
    for (int n = 0; n < 5; n++) step(1, 0, n, 0, 0, -1);
    for (int n = 0; n < 32; n++) step(1, n == 0, 160 + n, 0, 0, -1);
    pend_req = "R9";
    for (int j = 0; j < 32; j++) step(0, 0, 0, 1, j == 0, 160 + j);
    idle();
    status("R9", 0, 0, 0);

    summary();
  end

endmodule